// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Controller

This block is the coherence controller for one private write-through cache sitting on a shared broadcast bus. It keeps a small direct-mapped array in which every line holds a tag, one data word and a single valid bit. A line is therefore either Valid or Invalid, and coherence is tracked per line. Processor loads that hit a valid line are answered from the array without touching the bus. Loads that miss fetch the word from memory over the bus and fill the line.

Every processor store goes out on the bus as a bus write. A store that misses does not allocate a line. A store that hits also updates the local copy, so the cache never holds data that is newer than memory. The controller watches every write on the bus. When another agent writes to an address the cache holds, the matching line is dropped, and the next local load of that address fetches the new value from memory.

Bus transactions are atomic. The processor waits for the acknowledge of one request before it issues the next. A single grant input arbitrates the bus, and each agent tags its bus transactions with a requester ID.

Top module: `wti_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first load to any address misses. `cpu_ack`, `bus_req` and `bus_valid` are low after reset.
- R2: A load that misses issues exactly one bus read (`bus_write`=0) to `cpu_addr`. It returns the word that memory supplies on `bus_rdata` in the cycle after the read, and it makes the line Valid.
- R3: A load that hits is acknowledged in the clock cycle after it is accepted, with the stored data and with no bus transaction.
- R4: Every store issues exactly one bus write (`bus_write`=1) carrying `cpu_addr`, `cpu_wdata` and the controller's own ID on `bus_src`. It is acknowledged in the cycle after that bus write.
- R5: A store that hits updates the local copy in the cycle of its bus write, so a later load hits and returns the stored value.
- R6: A store that misses does not allocate, so a later load of that address misses.
- R7: A bus write by another agent (`obs_src` differs from the own ID) to a resident address makes that line Invalid. The next local load of that address misses and returns the value that was written.
- R8: A bus write by another agent to an address that shares an index with a resident line but has a different tag leaves that line Valid.
- R9: Bus writes carrying the controller's own ID never invalidate a line.
- R10: When a snooped invalidating write and an accepted load to the same line fall in the same cycle, the invalidation wins and the load is handled as a miss.
- R11: `bus_valid` is asserted only while `bus_gnt` is high. `bus_req` stays high from the cycle the bus read is issued until the read data is taken.
- R12: The index is `addr[IDX_W-1:0]` and the tag is the remaining upper address bits. A miss that fills an index replaces the previous line there, so a later load of the old address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ack` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Own transaction on the bus this cycle |
| bus_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_src | output | ID_W | Own requester ID |
| bus_rdata | input | DATA_W | Memory data, one cycle after a bus read |
| obs_valid | input | 1 | A transaction is seen on the shared bus |
| obs_write | input | 1 | The observed transaction is a write |
| obs_addr | input | ADDR_W | Observed address |
| obs_src | input | ID_W | Requester ID of the observed transaction |

## Verification
A valid bit that is wrong becomes visible at the ports on the next load to that address. A line that is wrongly Valid answers from the array with stale data and no bus read. A line that is wrongly Invalid produces a bus read that should not happen. Both show within one request of the fault, so every load compares both the returned data and whether a bus read occurred. A stale data word behind a correct valid bit shows only as wrong `cpu_rdata` on a hit, one cycle after the load is accepted.

// File: rtl/wti_pkg.sv
// Package: shared types of the write-through invalidating snoop controller.
// Assumes: one outstanding processor request, atomic bus transactions.
package wti_pkg;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_BUS  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_WR_BUS  = 2'd3
    } wti_state_e;

endpackage

// File: rtl/wti_snoop_filter.sv
// Module: wti_snoop_filter
// Turns an observed bus transaction into an invalidation request when it
// is a write issued by another agent. Assumes the observed bus carries a
// requester ID for every transaction, including this controller's own.
module wti_snoop_filter #(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 1
) (
    input  logic              obs_valid,
    input  logic              obs_write,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [ID_W-1:0]   obs_src,
    output logic              kill_req,
    output logic [ADDR_W-1:0] kill_addr
);
    localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

    // Foreign writes only: own writes already keep the local copy in step
    always_comb begin
        kill_req  = obs_valid && obs_write && (obs_src != OWN_ID);
        kill_addr = obs_addr;
    end
endmodule

// File: rtl/wti_tag_store.sv
// Module: wti_tag_store
// Direct-mapped array of lines: a valid bit, a tag and one data word each.
// One lookup port (shared by hit check, fill and write update) and one snoop
// port. A snoop that matches the looked-up line masks the hit in the same
// cycle. Assumes fill and snoop invalidation never coincide (atomic bus).
module wti_tag_store #(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              snp_req,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_data
);
    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic              snp_hit;

    // Snoop match and lookup hit; a same-line snoop masks the hit
    always_comb begin
        snp_hit = snp_req && vld_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
        lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag)
                  && !(snp_hit && (snp_idx == lk_idx));
        lk_data = data_q[lk_idx];
    end

    // Per-line valid bit: cleared by reset or snoop, set by fill
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
            end else if (fill_en && (lk_idx == IDX_W'(g))) begin
                vld_q[g] <= 1'b1;
            end else if (snp_hit && (snp_idx == IDX_W'(g))) begin
                vld_q[g] <= 1'b0;
            end
        end
    end

    // Tag and data write: fill on miss, word update on store hit
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[lk_idx]  <= lk_tag;
            data_q[lk_idx] <= fill_data;
        end else if (upd_en && lk_hit) begin
            data_q[lk_idx] <= upd_data;
        end
    end

    // R7: a snooped foreign write to a resident line leaves it Invalid
    a_r7_snoop_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && !fill_en) |=> !vld_q[$past(snp_idx)]);

    // R5: a store hit leaves the stored word in the line
    a_r5_store_hit_updates: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && lk_hit && !fill_en) |=> (data_q[$past(lk_idx)] == $past(upd_data)));

    // R2: a fill leaves the line Valid
    a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(lk_idx)]);
endmodule

// File: rtl/wti_ctrl_fsm.sv
// Module: wti_ctrl_fsm
// Sequences processor requests: a load hit answers at once, a load miss
// does a bus read and fill, and a store does a bus write (updating the line
// on a hit). Assumes cpu_req and its fields are held until cpu_ack and that
// memory returns read data on bus_rdata one cycle after the bus read.
module wti_ctrl_fsm
    import wti_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              fill_en,
    output logic              upd_en,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_write,
    input  logic [DATA_W-1:0] bus_rdata
);
    wti_state_e        state_q, state_d;
    logic              ack_q, ack_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              accept;

    // Next state, bus drive and response selection
    always_comb begin
        state_d   = state_q;
        ack_d     = 1'b0;
        rdata_d   = rdata_q;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        fill_en   = 1'b0;
        upd_en    = 1'b0;
        accept    = (state_q == ST_IDLE) && cpu_req && !ack_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cpu_we) begin
                        state_d = ST_WR_BUS;
                    end else if (lk_hit) begin
                        ack_d   = 1'b1;
                        rdata_d = lk_data;
                    end else begin
                        state_d = ST_RD_BUS;
                    end
                end
            end
            ST_RD_BUS: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_valid = 1'b1;
                    state_d   = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                bus_req = 1'b1;
                fill_en = 1'b1;
                ack_d   = 1'b1;
                rdata_d = bus_rdata;
                state_d = ST_IDLE;
            end
            ST_WR_BUS: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_valid = 1'b1;
                    bus_write = 1'b1;
                    upd_en    = 1'b1;
                    ack_d     = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
            rdata_q <= rdata_d;
        end
    end

    assign cpu_ack   = ack_q;
    assign cpu_rdata = rdata_q;

    // R11: own transactions appear only under grant
    a_r11_valid_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_gnt);

    // R11: bus held from a bus read until its data is taken
    a_r11_read_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> (bus_req && fill_en));

    // R4: a store is acknowledged the cycle after its bus write
    a_r4_write_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> cpu_ack);

    // R3: a load hit answers in the next cycle without a bus request
    a_r3_hit_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_we && lk_hit) |=> (cpu_ack && !bus_req));

    // R1: acknowledge is a single-cycle pulse
    a_r1_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
endmodule

// File: rtl/wti_snoop_ctrl.sv
// Module: wti_snoop_ctrl (top)
// Two-state (Valid/Invalid) coherence controller for a private write-through,
// no-allocate-on-store cache with bus-write snoop invalidation. Assumes
// atomic bus transactions under a single grant, one outstanding processor
// request, and an observed bus that shows every transaction with its ID.
module wti_snoop_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [ID_W-1:0]   bus_src,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              obs_valid,
    input  logic              obs_write,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [ID_W-1:0]   obs_src
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              kill_req;
    logic [ADDR_W-1:0] kill_addr;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              fill_en;
    logic              upd_en;

    // Bus payload follows the held processor request
    always_comb begin
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        bus_src   = ID_W'(MY_ID);
    end

    wti_snoop_filter #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W),
        .MY_ID  (MY_ID)
    ) u_filter (
        .obs_valid (obs_valid),
        .obs_write (obs_write),
        .obs_addr  (obs_addr),
        .obs_src   (obs_src),
        .kill_req  (kill_req),
        .kill_addr (kill_addr)
    );

    wti_tag_store #(
        .LINES  (LINES),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (cpu_addr[IDX_W-1:0]),
        .lk_tag    (cpu_addr[ADDR_W-1:IDX_W]),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .snp_req   (kill_req),
        .snp_idx   (kill_addr[IDX_W-1:0]),
        .snp_tag   (kill_addr[ADDR_W-1:IDX_W]),
        .fill_en   (fill_en),
        .fill_data (bus_rdata),
        .upd_en    (upd_en),
        .upd_data  (cpu_wdata)
    );

    wti_ctrl_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .fill_en   (fill_en),
        .upd_en    (upd_en),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_rdata (bus_rdata)
    );

    // R9: the controller's own bus writes never raise an invalidation
    a_r9_own_write_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && obs_valid && (obs_src == bus_src)) |-> !kill_req);
endmodule

// File: tb/wti_snoop_ctrl_bench.sv
// Scoreboard bench: the driver task queues the expected outcome of every
// processor request; the monitor compares acks and bus activity against it.
module wti_snoop_ctrl_bench;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int IW = 2;

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          miss;
        logic [DW-1:0] data;
        string         req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic bus_req, bus_gnt, bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic [IW-1:0] bus_src;
    logic f_valid = 1'b0;
    logic [AW-1:0] f_addr = '0;
    logic [DW-1:0] f_data = '0;
    logic [IW-1:0] f_src = 2'd2;
    logic blk = 1'b0;
    logic obs_valid, obs_write;
    logic [AW-1:0] obs_addr;
    logic [IW-1:0] obs_src;
    logic [DW-1:0] obs_wdata;
    logic [DW-1:0] mem [0:255];

    item_t q[$];
    int checks = 0, errors = 0;
    int saw_rd = 0, saw_wr = 0;

    always #2 clk = ~clk;

    // Shared bus: own transaction when granted, otherwise a foreign writer
    assign bus_gnt   = bus_req && !f_valid && !blk;
    assign obs_valid = bus_valid || f_valid;
    assign obs_write = bus_valid ? bus_write : 1'b1;
    assign obs_addr  = bus_valid ? bus_addr : f_addr;
    assign obs_src   = bus_valid ? bus_src : f_src;
    assign obs_wdata = bus_valid ? bus_wdata : f_data;

    function automatic logic [DW-1:0] init_val(input int a);
        return 32'hA5A50000 ^ (a * 32'h01010101);
    endfunction

    // Synchronous memory: write on any bus write, read data next cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            bus_rdata <= '0;
        end else begin
            if (obs_valid && obs_write) mem[obs_addr] <= obs_wdata;
            if (bus_valid && !bus_write) bus_rdata <= mem[bus_addr];
        end
    end

    wti_snoop_ctrl u_wti_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_src(bus_src), .bus_rdata(bus_rdata),
        .obs_valid(obs_valid), .obs_write(obs_write), .obs_addr(obs_addr), .obs_src(obs_src)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: grant discipline, bus write payload, and per-request outcome
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid && !bus_gnt) chk(1'b0, "R11 valid without grant", 1, 0);
            if (bus_valid && !bus_write) saw_rd++;
            if (bus_valid && bus_write) begin
                saw_wr++;
                if (q.size() > 0) begin
                    chk(bus_addr == q[0].addr, {q[0].req, " R4 bus addr"}, DW'(bus_addr), DW'(q[0].addr));
                    chk(bus_wdata == q[0].wdata, {q[0].req, " R4 bus data"}, bus_wdata, q[0].wdata);
                    chk(bus_src == 2'd1, {q[0].req, " R4 bus id"}, DW'(bus_src), 1);
                end
            end
            if (cpu_ack) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R1 unexpected ack", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (it.we) begin
                        chk(saw_wr == 1 && saw_rd == 0, {it.req, " store bus writes"}, saw_wr, 1);
                    end else begin
                        chk(cpu_rdata == it.data, {it.req, " load data"}, cpu_rdata, it.data);
                        chk(saw_rd == (it.miss ? 1 : 0) && saw_wr == 0,
                            {it.req, " load bus reads"}, saw_rd, it.miss ? 1 : 0);
                    end
                end
                saw_rd = 0;
                saw_wr = 0;
            end
        end
    end

    task automatic wait_ack();
        do @(negedge clk); while (!cpu_ack);
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic miss, input logic [DW-1:0] exp, input string req);
        item_t it;
        it = '{we, a, wd, miss, exp, req};
        q.push_back(it);
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
        wait_ack();
    endtask

    task automatic foreign_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        f_addr = a; f_data = d; f_src = 2'd2; f_valid = 1'b1;
        @(negedge clk);
        f_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(cpu_ack == 1'b0, "R1 ack after reset", DW'(cpu_ack), 0);
        chk(bus_req == 1'b0, "R1 bus_req after reset", DW'(bus_req), 0);
        chk(bus_valid == 1'b0, "R1 bus_valid after reset", DW'(bus_valid), 0);

        do_op(0, 8'h12, 0, 1, init_val(8'h12), "R1 R2 first load misses");
        do_op(0, 8'h12, 0, 0, init_val(8'h12), "R3 load hit");
        do_op(1, 8'h12, 32'hDEAD0001, 0, 0, "R4 store hit");
        do_op(0, 8'h12, 0, 0, 32'hDEAD0001, "R5 R9 hit after own store");
        do_op(1, 8'h33, 32'hBEEF0003, 0, 0, "R4 R6 store miss");
        do_op(0, 8'h33, 0, 1, 32'hBEEF0003, "R6 no allocate");

        foreign_wr(8'h12, 32'h11110000);
        do_op(0, 8'h12, 0, 1, 32'h11110000, "R7 foreign write invalidates");

        foreign_wr(8'h0A, 32'h22220000);
        do_op(0, 8'h12, 0, 0, 32'h11110000, "R8 other tag keeps line");
        do_op(0, 8'h0A, 0, 1, 32'h22220000, "R12 conflict fill");
        do_op(0, 8'h12, 0, 1, 32'h11110000, "R12 old tag misses");

        // R10: snoop and load to the same line in one cycle
        begin
            item_t it;
            it = '{1'b0, 8'h12, 32'h0, 1'b1, 32'h33330000, "R10 snoop beats load"};
            q.push_back(it);
            @(negedge clk);
            f_addr = 8'h12; f_data = 32'h33330000; f_src = 2'd2; f_valid = 1'b1;
            cpu_we = 1'b0; cpu_addr = 8'h12; cpu_req = 1'b1;
            @(negedge clk);
            f_valid = 1'b0;
            wait_ack();
        end

        // R11: delayed grant still yields one read and correct data
        blk = 1'b1;
        fork
            do_op(0, 8'h40, 0, 1, init_val(8'h40), "R11 delayed grant");
            begin repeat (4) @(negedge clk); blk = 1'b0; end
        join
        do_op(0, 8'h40, 0, 0, init_val(8'h40), "R3 hit after delayed fill");

        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R1 all requests acknowledged", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule